// File: doc/BRIEF.md
# Programmed-IO Transaction Sequencer

This block lets software run one short read or write on a downstream byte-oriented bus engine without a DMA setup. Software first fills a small word-addressed register file: a byte count, a target address, an opcode, and, for writes, a bank of 32-bit data words. It then writes the control register with the launch bit set. The sequencer then steps through the bytes. It presents each byte index on a request/acknowledge interface and, depending on the opcode, either sends bytes out of the bank or stores returned bytes into it.

When the last byte is acknowledged, the sequencer drops its busy state and sets a sticky completion flag. If software has enabled the completion interrupt, the interrupt line rises. While a transfer is running, the register file refuses every write and records that refusal in an error flag. A byte count larger than the bank is cut down to the bank size and flagged as an overflow.

Register map (word addresses): 0 control (bit 0 launch, bit 1 interrupt enable); 1 status (bit 0 busy, bit 1 done, bit 2 error, bit 3 overflow); 2 byte count; 3 target address; 4 opcode; 8 to 8+DATA_WORDS-1 data bank. Data byte k of the bank sits in word k/4, bits 8*(k%4)+7 down to 8*(k%4).

Top module: `pio_seq_top`

## Requirements
- R1: After reset, busy, done, error, overflow, irq and bus_req are 0, and the count, target, opcode and data registers read 0.
- R2: A control write with bit 0 set, made while idle with an effective count N>0, raises bus_req from the cycle after that write. It then issues exactly N byte requests with bus_idx 0..N-1 in order. Each request carries bus_addr equal to the target register and bus_op equal to the opcode register.
- R3: When opcode bit 0 is 0 (write), bus_wbyte for index k is bank byte k.
- R4: When opcode bit 0 is 1 (read), the byte returned with the acknowledge of index k is stored as bank byte k, and bank bytes at N and above are left unchanged.
- R5: The clock edge that accepts the acknowledge of the last byte clears busy and sets done.
- R6: irq equals done AND the interrupt-enable bit, as a level, including when the enable is set after done.
- R7: The launch bit always reads back as 0.
- R8: Any register write while busy changes no register and sets the error flag.
- R9: Done, error and overflow are sticky. Writing 1 to the matching status bit while idle clears that bit, and writing 0 leaves it as it was.
- R10: A count above 4*DATA_WORDS bytes is treated as 4*DATA_WORDS and sets the overflow flag.
- R11: A launch with count 0 sets done at the edge that accepts the launch write, never raises busy and issues no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| bus_req | output | 1 | Byte request to the bus engine |
| bus_rd | output | 1 | Request direction, 1 for read |
| bus_op | output | 8 | Opcode passed to the bus engine |
| bus_addr | output | ADDR_W | Target address |
| bus_idx | output | BSEL_W | Byte index within the transfer |
| bus_wbyte | output | 8 | Byte to send on writes |
| bus_ack | input | 1 | Bus engine accepts or returns the current byte |
| bus_rbyte | input | 8 | Returned byte on reads |
| irq | output | 1 | Completion interrupt |

## Verification
A launch write accepted at edge E shows bus_req after E. Each byte takes one cycle when the engine acknowledges at once, so busy drops and done, irq and the read-back bank bytes change after edge E+N. A zero-count launch shows done right after E. Status flags and refused writes take effect at the edge of the write that causes them. The bench drives inputs and samples outputs at the falling edge, so every value it reads was set by the rising edge before. Completion is found by polling the busy bit, and the number of acknowledged bytes is counted against N.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  // register word addresses
  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_STAT    = 1;
  localparam int unsigned A_COUNT   = 2;
  localparam int unsigned A_TARGET  = 3;
  localparam int unsigned A_OPCODE  = 4;
  localparam int unsigned DATA_BASE = 8;

  // effective transfer length after clamping to the bank size
  function automatic int unsigned clamp_len(int unsigned req, int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

  function automatic logic too_long(int unsigned req, int unsigned cap);
    return req > cap;
  endfunction
endpackage

// File: rtl/pio_seq_regs.sv
module pio_seq_regs
  import pio_seq_pkg::*;
#(
  parameter int DATA_WORDS = 4,
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int REG_AW     = 4,
  parameter int BANK_BYTES = 16,
  parameter int BSEL_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              busy,
  input  logic [2:0]        stat_q,
  output logic              go_pulse,
  output logic              wr_reject,
  output logic [2:0]        w1c_mask,
  output logic              irq_en,
  output logic [CNT_W-1:0]  count_q,
  output logic [ADDR_W-1:0] target_q,
  output logic [7:0]        opcode_q,
  input  logic [BSEL_W-1:0] wbyte_sel,
  output logic [7:0]        wbyte,
  input  logic              rd_we,
  input  logic [BSEL_W-1:0] rd_sel,
  input  logic [7:0]        rd_byte
);
  logic [BANK_BYTES-1:0][7:0] bank_q;
  logic wr_ok;

  assign wr_ok     = cfg_wr && !busy;
  assign wr_reject = cfg_wr && busy;
  assign go_pulse  = wr_ok && (cfg_addr == REG_AW'(A_CTRL)) && cfg_wdata[0];
  assign w1c_mask  = (wr_ok && cfg_addr == REG_AW'(A_STAT)) ? cfg_wdata[3:1] : 3'b000;
  assign wbyte     = bank_q[wbyte_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      count_q  <= '0;
      target_q <= '0;
      opcode_q <= '0;
      bank_q   <= '0;
    end else begin
      if (wr_ok) begin
        if (cfg_addr == REG_AW'(A_CTRL))   irq_en   <= cfg_wdata[1];
        if (cfg_addr == REG_AW'(A_COUNT))  count_q  <= cfg_wdata[CNT_W-1:0];
        if (cfg_addr == REG_AW'(A_TARGET)) target_q <= cfg_wdata[ADDR_W-1:0];
        if (cfg_addr == REG_AW'(A_OPCODE)) opcode_q <= cfg_wdata[7:0];
        for (int w = 0; w < DATA_WORDS; w++)
          if (cfg_addr == REG_AW'(DATA_BASE + w)) bank_q[w*4 +: 4] <= cfg_wdata;
      end
      if (rd_we) bank_q[rd_sel] <= rd_byte;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == REG_AW'(A_CTRL))   cfg_rdata = {30'd0, irq_en, 1'b0};
    if (cfg_addr == REG_AW'(A_STAT))   cfg_rdata = {28'd0, stat_q, busy};
    if (cfg_addr == REG_AW'(A_COUNT))  cfg_rdata = 32'(count_q);
    if (cfg_addr == REG_AW'(A_TARGET)) cfg_rdata = 32'(target_q);
    if (cfg_addr == REG_AW'(A_OPCODE)) cfg_rdata = 32'(opcode_q);
    for (int w = 0; w < DATA_WORDS; w++)
      if (cfg_addr == REG_AW'(DATA_BASE + w)) cfg_rdata = bank_q[w*4 +: 4];
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr) |=> ($stable(count_q) && $stable(target_q) && $stable(opcode_q) && $stable(irq_en))); // R8
endmodule

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
  import pio_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int BANK_BYTES = 16,
  parameter int BSEL_W     = 4,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_pulse,
  input  logic [CNT_W-1:0]  count_q,
  input  logic [7:0]        opcode_q,
  input  logic              bus_ack,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_rd,
  output logic [BSEL_W-1:0] byte_sel,
  output logic              rd_we,
  output logic              fin,
  output logic              ovf_set
);
  logic [IDX_W-1:0] idx_q, len_q, eff_len;
  logic             busy_q, rd_q, last;

  assign eff_len  = IDX_W'(clamp_len(32'(count_q), BANK_BYTES));
  assign ovf_set  = go_pulse && too_long(32'(count_q), BANK_BYTES);
  assign last     = (idx_q == len_q - 1'b1);
  assign busy     = busy_q;
  assign bus_req  = busy_q;
  assign bus_rd   = rd_q;
  assign byte_sel = idx_q[BSEL_W-1:0];
  assign rd_we    = busy_q && bus_ack && rd_q;
  assign fin      = (busy_q && bus_ack && last) || (go_pulse && eff_len == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
    end else if (!busy_q) begin
      if (go_pulse && eff_len != '0) begin
        busy_q <= 1'b1;
        rd_q   <= opcode_q[0];
        idx_q  <= '0;
        len_q  <= eff_len;
      end
    end else if (bus_ack) begin
      idx_q <= idx_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q < len_q && len_q <= IDX_W'(BANK_BYTES))); // R10
  AST_GO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse && eff_len != '0) |=> (bus_req && idx_q == '0)); // R2
  AST_FIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !bus_req); // R5
endmodule

// File: rtl/pio_seq_irq.sv
module pio_seq_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_done,
  input  logic       set_err,
  input  logic       set_ovf,
  input  logic [2:0] w1c_mask,
  input  logic       irq_en,
  output logic [2:0] stat_q,
  output logic       irq
);
  logic done_q, err_q, ovf_q;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= set_done | (done_q & ~w1c_mask[0]);
      err_q  <= set_err  | (err_q  & ~w1c_mask[1]);
      ovf_q  <= set_ovf  | (ovf_q  & ~w1c_mask[2]);
    end
  end

  assign stat_q = {ovf_q, err_q, done_q};
  assign irq    = done_q & irq_en;

  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !w1c_mask[0]) |=> done_q); // R9
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> err_q); // R8
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> done_q); // R5
endmodule

// File: rtl/pio_seq_top.sv
module pio_seq_top #(
  parameter int DATA_WORDS = 4,
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = 16,
  localparam int BANK_BYTES = DATA_WORDS * 4,
  localparam int BSEL_W     = $clog2(BANK_BYTES),
  localparam int IDX_W      = $clog2(BANK_BYTES + 1),
  localparam int REG_AW     = $clog2(pio_seq_pkg::DATA_BASE + DATA_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              bus_req,
  output logic              bus_rd,
  output logic [7:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BSEL_W-1:0] bus_idx,
  output logic [7:0]        bus_wbyte,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rbyte,
  output logic              irq
);
  logic              busy, go_pulse, wr_reject, irq_en, rd_we, fin, ovf_set;
  logic [2:0]        w1c_mask, stat_q;
  logic [CNT_W-1:0]  count_q;
  logic [BSEL_W-1:0] byte_sel;

  pio_seq_regs #(
    .DATA_WORDS(DATA_WORDS), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .REG_AW(REG_AW), .BANK_BYTES(BANK_BYTES), .BSEL_W(BSEL_W)
  ) u_regs (
    .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .busy, .stat_q, .go_pulse, .wr_reject, .w1c_mask, .irq_en, .count_q,
    .target_q(bus_addr), .opcode_q(bus_op),
    .wbyte_sel(byte_sel), .wbyte(bus_wbyte),
    .rd_we, .rd_sel(byte_sel), .rd_byte(bus_rbyte)
  );

  pio_seq_fsm #(
    .CNT_W(CNT_W), .BANK_BYTES(BANK_BYTES), .BSEL_W(BSEL_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk, .rst_n, .go_pulse, .count_q, .opcode_q(bus_op), .bus_ack,
    .busy, .bus_req, .bus_rd, .byte_sel, .rd_we, .fin, .ovf_set
  );

  pio_seq_irq u_irq (
    .clk, .rst_n, .set_done(fin), .set_err(wr_reject), .set_ovf(ovf_set),
    .w1c_mask, .irq_en, .stat_q, .irq
  );

  assign bus_idx = byte_sel;

  AST_NO_REQ_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && fin) |=> (!bus_req && stat_q[0])); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse && count_q == '0) |=> !bus_req); // R11
endmodule

// File: tb/pio_seq_top_tb.sv
module pio_seq_top_tb;
  localparam int NW = 4, NB = 16, RAW = 4, BSW = 4;

  logic           clk = 1'b0, rst_n = 1'b0;
  logic           cfg_wr = 1'b0;
  logic [RAW-1:0] cfg_addr = '0;
  logic [31:0]    cfg_wdata = '0, cfg_rdata;
  logic           bus_req, bus_rd, bus_ack = 1'b0, irq;
  logic [7:0]     bus_op, bus_wbyte, bus_rbyte = '0;
  logic [15:0]    bus_addr;
  logic [BSW-1:0] bus_idx;

  int checks = 0, errors = 0, cycles = 0;
  int nreq = 0, order_bad = 0, addr_bad = 0;
  logic [7:0]  seen_wr [NB];
  logic [15:0] exp_tgt = '0;
  logic [7:0]  exp_op = '0;

  pio_seq_top u_dut (
    .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .bus_req, .bus_rd, .bus_op, .bus_addr, .bus_idx, .bus_wbyte,
    .bus_ack, .bus_rbyte, .irq
  );

  always #5 clk = ~clk;

  // read data the model engine returns
  function automatic logic [7:0] rmodel(logic [15:0] a, int k);
    return 8'(a[7:0] + 8'(3 * k) + 8'h5A);
  endfunction
  // preload word pattern
  function automatic logic [31:0] wpat(int v, int w);
    return 32'hC0DE0000 | 32'(v << 8) | 32'(w * 17);
  endfunction

  // single-cycle-acknowledge bus engine
  always @(negedge clk) begin
    bus_ack   <= bus_req;
    bus_rbyte <= rmodel(bus_addr, int'(bus_idx));
    if (bus_req) begin
      if (int'(bus_idx) != nreq) order_bad++;
      if (bus_addr != exp_tgt || bus_op != exp_op) addr_bad++;
      if (!bus_rd) seen_wr[bus_idx] = bus_wbyte;
      nreq++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = RAW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    cfg_addr = RAW'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      rd(1, s);
      if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  // program, launch, return at the falling edge just after the launch edge
  task automatic launch(input logic [7:0] op, input int cnt, input logic [15:0] tgt, input bit ien);
    wr(2, 32'(cnt)); wr(3, 32'(tgt)); wr(4, 32'(op));
    exp_tgt = tgt; exp_op = op; nreq = 0; order_bad = 0; addr_bad = 0;
    wr(0, {30'd0, ien, 1'b1});
  endtask

  localparam logic [31:0] VEC [4] = '{32'h01051234, 32'h021000A0, 32'h03107F00, 32'h00030042};

  initial begin
    logic [31:0] r, s;
    int eff;
    repeat (3) @(negedge clk);
    rd(1, s);
    chk(s == 32'd0 && !irq && !bus_req, "R1 status/irq/req after reset", s, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 2; a < 12; a++) begin
      if (a > 4 && a < 8) continue;
      rd(a, r);
      chk(r == 32'd0, "R1 register zero after reset", r, 0);
    end

    // vector table
    for (int v = 0; v < 4; v++) begin
      logic [7:0] op; int cnt; logic [15:0] tgt;
      op = VEC[v][31:24]; cnt = int'(VEC[v][23:16]); tgt = VEC[v][15:0];
      for (int w = 0; w < NW; w++) wr(8 + w, wpat(v, w));
      wr(1, 32'hE);
      launch(op, cnt, tgt, 1'b1);
      chk(bus_req === 1'b1, "R2 req after launch", 32'(bus_req), 1);
      rd(0, r);
      chk(r[0] == 1'b0, "R7 launch bit reads 0", r, 32'(r[1]) << 1);
      wait_idle();
      chk(nreq == cnt && order_bad == 0 && addr_bad == 0, "R2 request count/order/addr",
          32'(nreq), 32'(cnt));
      rd(1, s);
      chk(s[1:0] == 2'b10, "R5 done set busy clear", s, 32'h2);
      chk(irq === 1'b1, "R6 irq with enable", 32'(irq), 1);
      for (int k = 0; k < NB; k++) begin
        logic [7:0] pre;
        pre = wpat(v, k / 4) >> (8 * (k % 4));
        rd(8 + k / 4, r);
        if (op[0]) begin
          chk(r[8*(k%4) +: 8] == (k < cnt ? rmodel(tgt, k) : pre), "R4 read bank byte",
              32'(r[8*(k%4) +: 8]), 32'(k < cnt ? rmodel(tgt, k) : pre));
        end else if (k < cnt) begin
          chk(seen_wr[k] == pre, "R3 write byte", 32'(seen_wr[k]), 32'(pre));
        end
      end
      wr(1, 32'h0);
      rd(1, s);
      chk(s[1] == 1'b1, "R9 write 0 keeps done", s, 32'h2);
      wr(1, 32'h2);
      rd(1, s);
      chk(s == 32'd0 && !irq, "R9 write 1 clears done", s, 0);
    end

    // R8: write while busy
    launch(8'h01, 16, 16'h0300, 1'b1);
    wr(2, 32'd7);
    wr(8, 32'hDEADBEEF);
    wait_idle();
    rd(2, r);
    chk(r == 32'd16, "R8 count unchanged by busy write", r, 16);
    rd(8, r);
    chk(r == {rmodel(16'h0300, 3), rmodel(16'h0300, 2), rmodel(16'h0300, 1), rmodel(16'h0300, 0)},
        "R8 data unchanged by busy write", r, 0);
    rd(1, s);
    chk(s[2] == 1'b1, "R8 error flag set", s, 32'h6);
    wr(1, 32'h4);
    rd(1, s);
    chk(s[2] == 1'b0 && s[1] == 1'b1, "R9 clear error only", s, 32'h2);
    wr(1, 32'hE);

    // R10: clamp
    launch(8'h00, 20, 16'h0011, 1'b1);
    wait_idle();
    rd(1, s);
    chk(nreq == NB && s[3] == 1'b1, "R10 clamp and overflow", 32'(nreq), NB);
    wr(1, 32'hE);

    // R11: zero count
    launch(8'h01, 0, 16'h0022, 1'b1);
    rd(1, s);
    chk(!bus_req && s[1:0] == 2'b10, "R11 zero count done at once", s, 32'h2);
    repeat (3) @(negedge clk);
    chk(nreq == 0, "R11 no bus request", 32'(nreq), 0);
    wr(1, 32'hE);

    // R6: masked, then enabled afterwards
    launch(8'h00, 2, 16'h0033, 1'b0);
    wait_idle();
    rd(1, s);
    chk(s[1] == 1'b1 && irq === 1'b0, "R6 irq masked", 32'(irq), 0);
    wr(0, 32'h2);
    chk(irq === 1'b1, "R6 irq on late enable", 32'(irq), 1);
    rd(0, r);
    chk(r == 32'h2, "R7 control readback", r, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule